// File: doc/BRIEF.md
# Transmit Endpoint Packet Buffer with Flush and Abort

This block holds outgoing packets for a single transmit endpoint of a USB-style controller. The CPU streams bytes in through a byte write port. It then commits the packet by writing the ready bit of a three-bit control/status register. A downstream transmit engine drains committed packets one at a time, oldest first. The engine uses a valid/ready stream that marks the final byte of each packet. The buffer runs with one packet slot, or with two slots when the double-buffer enable is high. In two-slot mode the CPU can fill one slot while the other waits or is being sent.

Packet-ready is owned by the hardware. The CPU can set it, but writing 0 never clears it. The block clears it itself when the last committed packet leaves, or when a flush removes that packet. A flush write removes one packet per write, always the most recently committed one. In two-slot mode the CPU therefore writes flush twice to empty the buffer. Writing flush together with ready aborts the packet that is still being loaded. A flush written while packet-ready is clear does nothing. Completions, flushes and aborts each raise a one-cycle interrupt pulse, which is also held in a sticky status bit.

The double-buffer enable is taken into use only while the buffer is completely idle. Idle means no committed packet, no partial bytes, and no access in that cycle.

Top module: `ep_tx_buf`

## Requirements
- R1: After reset, packet-ready, not-empty, interrupt status, `irq` and `tx_valid` are all 0.
- R2: A control write with bit 0 set and bit 1 clear commits the bytes loaded so far. Packet-ready (read bit 0) then reads 1. The bytes appear on `tx_data` in write order, held stable while `tx_ready` is low, with `tx_last` on the final byte. A commit with no loaded bytes is ignored.
- R3: When the final byte of a packet is accepted, its slot is freed. Packet-ready clears once no committed packet remains. `irq` pulses for one cycle in the cycle after the acceptance, and status (read bit 2) is set.
- R4: A write with bit 1 set and bit 0 clear, issued while packet-ready is 1, discards the most recently committed packet and any partial load. It resets the write position and pulses `irq`.
- R5: With two slots and two committed packets, one flush leaves packet-ready at 1 and the older packet still transmits intact. A second flush empties the buffer.
- R6: A write with bits 0 and 1 both set discards the partial load and pulses `irq`, and leaves committed packets untouched. The next byte written starts a new packet.
- R7: A flush written while packet-ready is 0 changes nothing: partial bytes are kept and no interrupt is raised.
- R8: Writing 0 to bit 0 never clears packet-ready. It falls only on a final-byte acceptance or a flush.
- R9: Not-empty (read bit 1) reads 1 whenever any byte is held, committed or partially loaded. It is therefore 1 whenever packet-ready is 1.
- R10: Writing 1 to bit 2 clears the interrupt status. A new interrupt in the same cycle wins.
- R11: In one-slot mode, byte writes and commits are ignored while a packet is committed. In two-slot mode a second packet can be loaded and committed behind the first, and packets leave in commit order.
- R12: Bytes written beyond `MAX_PKT` into one packet are dropped, and the committed length stops at `MAX_PKT`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbl_en | input | 1 | Two-slot mode request, adopted when idle |
| csr_wr | input | 1 | Control register write strobe |
| csr_wdata | input | 3 | Bit 0 ready/commit, bit 1 flush, bit 2 interrupt clear |
| csr_rdata | output | 3 | Bit 0 packet-ready, bit 1 not-empty, bit 2 interrupt status |
| dat_wr | input | 1 | Byte write strobe |
| dat_wdata | input | DATA_W | Byte to load |
| tx_valid | output | 1 | Transmit byte available |
| tx_data | output | DATA_W | Transmit byte |
| tx_last | output | 1 | Final byte of the packet |
| tx_ready | input | 1 | Transmit engine accepts the byte |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench builds the block with two slots, an 8-bit byte and `MAX_PKT` of 4. The small packet size lets a six-byte burst show the length limit within a few cycles. The two slots let the bench toggle `dbl_en` between scenarios and drive both modes from one build. The one-slot rules are checked with the enable low. The two-flush sequence, ordered draining and aborting behind a committed packet are checked with it high.

// File: rtl/ep_tx_pkg.sv
package ep_tx_pkg;
   localparam int CSR_W     = 3;
   localparam int BIT_RDY   = 0;
   localparam int BIT_FLUSH = 1;
   localparam int BIT_ICLR  = 2;

   typedef enum logic [1:0] {
      CMD_NONE,
      CMD_COMMIT,
      CMD_FLUSH,
      CMD_ABORT
   } cpu_cmd_e;

   function automatic cpu_cmd_e decode_cmd(input logic wr, input logic rdy, input logic fl);
      if (!wr)             return CMD_NONE;
      else if (rdy && fl)  return CMD_ABORT;
      else if (fl)         return CMD_FLUSH;
      else if (rdy)        return CMD_COMMIT;
      else                 return CMD_NONE;
   endfunction
endpackage

// File: rtl/ep_tx_slot_mem.sv
module ep_tx_slot_mem #(
   parameter int DATA_W  = 8,
   parameter int MAX_PKT = 64,
   parameter int NSLOT   = 2,
   localparam int IDX_W  = $clog2(MAX_PKT),
   localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [SLOT_W-1:0] wr_slot,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [SLOT_W-1:0] rd_slot,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] slot_q [NSLOT];

   for (genvar g = 0; g < NSLOT; g++) begin : g_slot
      logic [DATA_W-1:0] mem [MAX_PKT];

      always_ff @(posedge clk) begin
         if (wr_en && (wr_slot == SLOT_W'(g)))
            mem[wr_idx] <= wr_data;
      end

      assign slot_q[g] = mem[rd_idx];
   end

   if (NSLOT == 1) begin : g_rd_single
      logic unused_rd;
      assign unused_rd = ^rd_slot;
      assign rd_data   = slot_q[0];
   end else begin : g_rd_multi
      assign rd_data = slot_q[rd_slot];
   end
endmodule

// File: rtl/ep_tx_irq.sv
module ep_tx_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   input  logic clr,
   output logic irq,
   output logic stat
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq  <= 1'b0;
         stat <= 1'b0;
      end else begin
         irq  <= evt;
         stat <= evt | (stat & ~clr);
      end
   end
endmodule

// File: rtl/ep_tx_ctrl.sv
module ep_tx_ctrl
   import ep_tx_pkg::*;
#(
   parameter int MAX_PKT = 64,
   parameter int NSLOT   = 2,
   localparam int IDX_W  = $clog2(MAX_PKT),
   localparam int CNT_W  = $clog2(MAX_PKT + 1),
   localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dbl_en,
   input  cpu_cmd_e          cmd,
   input  logic              dat_wr,
   input  logic              tx_ready,
   output logic              mem_we,
   output logic [SLOT_W-1:0] mem_wslot,
   output logic [IDX_W-1:0]  mem_widx,
   output logic [SLOT_W-1:0] mem_rslot,
   output logic [IDX_W-1:0]  mem_ridx,
   output logic              tx_valid,
   output logic              tx_last,
   output logic              pkt_rdy,
   output logic              not_empty,
   output logic              irq_evt
);
   logic [SLOT_W-1:0] head_q, head_d, ld_slot;
   logic [1:0]        ncnt_q, ncnt_d, cap, remain;
   logic [CNT_W-1:0]  wcnt_q, wcnt_d, fill, len_head;
   logic [CNT_W-1:0]  len_q [NSLOT];
   logic [IDX_W-1:0]  ridx_q, ridx_d;
   logic              dual;
   logic              load_free, room, dat_acc;
   logic              step, done, flush_hit, abort_hit, commit_ok, adopt;

   // mode selection: fixed single slot, or a register adopted when idle
   if (NSLOT == 2) begin : g_dual
      logic dual_q;
      always_ff @(posedge clk) begin
         if (!rst_n)     dual_q <= 1'b0;
         else if (adopt) dual_q <= dbl_en;
      end
      assign dual = dual_q;
   end else begin : g_single
      assign dual = dbl_en & 1'b0;
   end

   assign cap       = dual ? 2'd2 : 2'd1;
   assign load_free = ncnt_q < cap;
   assign ld_slot   = (dual && ncnt_q == 2'd1) ? (head_q ^ SLOT_W'(1)) : head_q;
   assign room      = wcnt_q < CNT_W'(MAX_PKT);
   assign dat_acc   = dat_wr && load_free && room;
   assign fill      = wcnt_q + CNT_W'(dat_acc);
   assign len_head  = len_q[head_q];

   assign tx_valid  = ncnt_q != 2'd0;
   assign tx_last   = tx_valid && (CNT_W'(ridx_q) == len_head - CNT_W'(1));
   assign step      = tx_valid && tx_ready;
   assign done      = step && tx_last;

   assign remain    = ncnt_q - 2'(done);
   assign flush_hit = (cmd == CMD_FLUSH) && (remain != 2'd0);
   assign abort_hit = cmd == CMD_ABORT;
   assign commit_ok = (cmd == CMD_COMMIT) && load_free && (fill != '0);
   assign adopt     = (ncnt_q == 2'd0) && (wcnt_q == '0) && !dat_wr && (cmd == CMD_NONE);

   always_comb begin
      ncnt_d = ncnt_q - 2'(done) + 2'(commit_ok) - 2'(flush_hit);

      if (adopt)              head_d = '0;
      else if (done && dual)  head_d = head_q ^ SLOT_W'(1);
      else                    head_d = head_q;

      if (done || (flush_hit && ncnt_q == 2'd1)) ridx_d = '0;
      else if (step)                             ridx_d = ridx_q + IDX_W'(1);
      else                                       ridx_d = ridx_q;

      if (flush_hit || abort_hit || commit_ok) wcnt_d = '0;
      else                                     wcnt_d = fill;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q <= '0;
         ncnt_q <= 2'd0;
         wcnt_q <= '0;
         ridx_q <= '0;
         for (int s = 0; s < NSLOT; s++) len_q[s] <= '0;
      end else begin
         head_q <= head_d;
         ncnt_q <= ncnt_d;
         wcnt_q <= wcnt_d;
         ridx_q <= ridx_d;
         for (int s = 0; s < NSLOT; s++)
            if (commit_ok && ld_slot == SLOT_W'(s)) len_q[s] <= fill;
      end
   end

   assign mem_we    = dat_acc;
   assign mem_wslot = ld_slot;
   assign mem_widx  = wcnt_q[IDX_W-1:0];
   assign mem_rslot = head_q;
   assign mem_ridx  = ridx_q;

   assign pkt_rdy   = ncnt_q != 2'd0;
   assign not_empty = pkt_rdy || (wcnt_q != '0);
   assign irq_evt   = done || flush_hit || abort_hit;
endmodule

// File: rtl/ep_tx_buf.sv
module ep_tx_buf
   import ep_tx_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int MAX_PKT = 64,
   parameter int NSLOT   = 2,
   localparam int IDX_W  = $clog2(MAX_PKT),
   localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dbl_en,
   input  logic              csr_wr,
   input  logic [2:0]        csr_wdata,
   output logic [2:0]        csr_rdata,
   input  logic              dat_wr,
   input  logic [DATA_W-1:0] dat_wdata,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_data,
   output logic              tx_last,
   input  logic              tx_ready,
   output logic              irq
);
   if (NSLOT < 1 || NSLOT > 2) begin : g_bad_nslot
      $error("ep_tx_buf: NSLOT must be 1 or 2");
   end
   if (MAX_PKT < 2) begin : g_bad_maxpkt
      $error("ep_tx_buf: MAX_PKT must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_dataw
      $error("ep_tx_buf: DATA_W must be positive");
   end

   cpu_cmd_e          cmd;
   logic              mem_we;
   logic [SLOT_W-1:0] mem_wslot, mem_rslot;
   logic [IDX_W-1:0]  mem_widx, mem_ridx;
   logic              pkt_rdy, not_empty, irq_evt, irq_stat, irq_clr;

   assign cmd     = decode_cmd(csr_wr, csr_wdata[BIT_RDY], csr_wdata[BIT_FLUSH]);
   assign irq_clr = csr_wr && csr_wdata[BIT_ICLR];

   ep_tx_ctrl #(.MAX_PKT(MAX_PKT), .NSLOT(NSLOT)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .dbl_en    (dbl_en),
      .cmd       (cmd),
      .dat_wr    (dat_wr),
      .tx_ready  (tx_ready),
      .mem_we    (mem_we),
      .mem_wslot (mem_wslot),
      .mem_widx  (mem_widx),
      .mem_rslot (mem_rslot),
      .mem_ridx  (mem_ridx),
      .tx_valid  (tx_valid),
      .tx_last   (tx_last),
      .pkt_rdy   (pkt_rdy),
      .not_empty (not_empty),
      .irq_evt   (irq_evt)
   );

   ep_tx_slot_mem #(.DATA_W(DATA_W), .MAX_PKT(MAX_PKT), .NSLOT(NSLOT)) u_mem (
      .clk     (clk),
      .wr_en   (mem_we),
      .wr_slot (mem_wslot),
      .wr_idx  (mem_widx),
      .wr_data (dat_wdata),
      .rd_slot (mem_rslot),
      .rd_idx  (mem_ridx),
      .rd_data (tx_data)
   );

   ep_tx_irq u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   (irq_evt),
      .clr   (irq_clr),
      .irq   (irq),
      .stat  (irq_stat)
   );

   always_comb begin
      csr_rdata            = '0;
      csr_rdata[BIT_RDY]   = pkt_rdy;
      csr_rdata[BIT_FLUSH] = not_empty;
      csr_rdata[BIT_ICLR]  = irq_stat;
   end
endmodule

// File: rtl/ep_tx_buf_chk.sv
module ep_tx_buf_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              csr_wr,
   input logic [2:0]        csr_wdata,
   input logic [2:0]        csr_rdata,
   input logic              tx_valid,
   input logic [DATA_W-1:0] tx_data,
   input logic              tx_last,
   input logic              tx_ready,
   input logic              irq
);
   logic fin;
   assign fin = tx_valid && tx_ready && tx_last;

   // R2
   tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready && !csr_wr) |=> (tx_valid && $stable(tx_data)));

   // R3
   done_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> irq);

   // R3
   irq_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> csr_rdata[2]);

   // R4
   flush_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_wr && csr_wdata[1] && !csr_wdata[0] && csr_rdata[0]) |=> irq);

   // R6
   abort_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_wr && csr_wdata[1] && csr_wdata[0]) |=> irq);

   // R7
   idle_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_wr && csr_wdata[1] && !csr_wdata[0] && !csr_rdata[0]) |=> !irq);

   // R8
   rdy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_rdata[0] && !fin && !(csr_wr && csr_wdata[1])) |=> csr_rdata[0]);

   // R9
   not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      csr_rdata[0] |-> csr_rdata[1]);

   // R10
   stat_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_wr && csr_wdata[2] && !csr_wdata[1] && !fin) |=> !csr_rdata[2]);
endmodule

bind ep_tx_buf ep_tx_buf_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .csr_wr    (csr_wr),
   .csr_wdata (csr_wdata),
   .csr_rdata (csr_rdata),
   .tx_valid  (tx_valid),
   .tx_data   (tx_data),
   .tx_last   (tx_last),
   .tx_ready  (tx_ready),
   .irq       (irq)
);

// File: tb/tb_ep_tx_buf.sv
module tb_ep_tx_buf;
   localparam int DW  = 8;
   localparam int MAX = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          dbl_en = 1'b0;
   logic          csr_wr = 1'b0;
   logic [2:0]    csr_wdata = '0;
   logic [2:0]    csr_rdata;
   logic          dat_wr = 1'b0;
   logic [DW-1:0] dat_wdata = '0;
   logic          tx_valid, tx_last, irq;
   logic [DW-1:0] tx_data;
   logic          tx_ready = 1'b0;

   int n_cmp = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   ep_tx_buf #(.DATA_W(DW), .MAX_PKT(MAX), .NSLOT(2)) dut (
      .clk(clk), .rst_n(rst_n), .dbl_en(dbl_en),
      .csr_wr(csr_wr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
      .dat_wr(dat_wr), .dat_wdata(dat_wdata),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
      .tx_ready(tx_ready), .irq(irq)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // all tasks start and end just after a falling edge
   task automatic tick();
      @(negedge clk);
   endtask

   task automatic csr_w(input logic [2:0] v);
      csr_wr = 1'b1; csr_wdata = v;
      @(negedge clk);
      csr_wr = 1'b0; csr_wdata = '0;
   endtask

   task automatic load(input int base, input int n);
      for (int i = 0; i < n; i++) begin
         dat_wr = 1'b1; dat_wdata = DW'(base + i);
         @(negedge clk);
      end
      dat_wr = 1'b0;
   endtask

   task automatic drain(input string req, input int base, input int n);
      tx_ready = 1'b1;
      for (int i = 0; i < n; i++) begin
         chk(req, "tx_valid", int'(tx_valid), 1);
         chk(req, "tx_data", int'(tx_data), base + i);
         chk(req, "tx_last", int'(tx_last), (i == n - 1) ? 1 : 0);
         @(negedge clk);
      end
      tx_ready = 1'b0;
      chk("R3", "irq after last byte", int'(irq), 1);
   endtask

   task automatic clr_stat();
      csr_w(3'b100);
      tick();
   endtask

   task automatic t_reset();
      chk("R1", "rdata", int'(csr_rdata), 0);
      chk("R1", "tx_valid", int'(tx_valid), 0);
      chk("R1", "irq", int'(irq), 0);
      csr_w(3'b001);
      chk("R2", "empty commit ready", int'(csr_rdata[0]), 0);
   endtask

   task automatic t_single_basic();
      load(8'h10, 3);
      chk("R9", "partial not-empty", int'(csr_rdata[1]), 1);
      chk("R9", "partial ready", int'(csr_rdata[0]), 0);
      csr_w(3'b001);
      chk("R2", "ready after commit", int'(csr_rdata[0]), 1);
      load(8'hEE, 1);
      csr_w(3'b001);
      drain("R2", 8'h10, 3);
      chk("R3", "ready after drain", int'(csr_rdata[0]), 0);
      chk("R11", "ignored byte left nothing", int'(csr_rdata[1]), 0);
      chk("R3", "status set", int'(csr_rdata[2]), 1);
      tick();
      chk("R3", "irq one cycle", int'(irq), 0);
      csr_w(3'b100);
      chk("R10", "status cleared", int'(csr_rdata[2]), 0);
   endtask

   task automatic t_write_zero_then_flush();
      load(8'h20, 2);
      csr_w(3'b001);
      csr_w(3'b000);
      chk("R8", "ready kept after 0 write", int'(csr_rdata[0]), 1);
      csr_w(3'b010);
      chk("R4", "flush irq", int'(irq), 1);
      chk("R4", "ready after flush", int'(csr_rdata[0]), 0);
      chk("R4", "empty after flush", int'(csr_rdata[1]), 0);
      chk("R4", "tx_valid after flush", int'(tx_valid), 0);
      clr_stat();
   endtask

   task automatic t_idle_flush();
      load(8'h30, 2);
      csr_w(3'b010);
      chk("R7", "no irq", int'(irq), 0);
      chk("R7", "status untouched", int'(csr_rdata[2]), 0);
      chk("R7", "bytes kept", int'(csr_rdata[1]), 1);
      csr_w(3'b001);
      drain("R7", 8'h30, 2);
      clr_stat();
   endtask

   task automatic t_abort_single();
      load(8'h40, 3);
      csr_w(3'b011);
      chk("R6", "abort irq", int'(irq), 1);
      chk("R6", "abort empty", int'(csr_rdata[1]), 0);
      chk("R6", "abort ready", int'(csr_rdata[0]), 0);
      load(8'h50, 1);
      csr_w(3'b001);
      drain("R6", 8'h50, 1);
      clr_stat();
   endtask

   task automatic t_overflow();
      load(8'h60, 6);
      csr_w(3'b001);
      drain("R12", 8'h60, MAX);
      chk("R12", "ready after limited packet", int'(csr_rdata[0]), 0);
      clr_stat();
   endtask

   task automatic t_dual_order();
      dbl_en = 1'b1;
      tick(); tick();
      load(8'h70, 2);
      csr_w(3'b001);
      load(8'h80, 3);
      csr_w(3'b001);
      drain("R11", 8'h70, 2);
      chk("R11", "ready with one left", int'(csr_rdata[0]), 1);
      drain("R11", 8'h80, 3);
      chk("R3", "ready when none left", int'(csr_rdata[0]), 0);
      clr_stat();
   endtask

   task automatic t_dual_flush();
      load(8'h90, 2);
      csr_w(3'b001);
      load(8'hA0, 2);
      csr_w(3'b001);
      csr_w(3'b010);
      chk("R5", "ready after one flush", int'(csr_rdata[0]), 1);
      drain("R5", 8'h90, 2);
      chk("R5", "empty after older sent", int'(csr_rdata[1]), 0);
      clr_stat();
      load(8'hB0, 1);
      csr_w(3'b001);
      load(8'hC0, 1);
      csr_w(3'b001);
      csr_w(3'b010);
      csr_w(3'b010);
      chk("R5", "ready after two flushes", int'(csr_rdata[0]), 0);
      chk("R5", "tx_valid after two flushes", int'(tx_valid), 0);
      clr_stat();
   endtask

   task automatic t_dual_abort();
      load(8'hD0, 2);
      csr_w(3'b001);
      load(8'hE0, 2);
      csr_w(3'b011);
      chk("R6", "ready kept by abort", int'(csr_rdata[0]), 1);
      load(8'hF0, 1);
      csr_w(3'b001);
      drain("R6", 8'hD0, 2);
      drain("R6", 8'hF0, 1);
      clr_stat();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick();
      t_reset();
      t_single_basic();
      t_write_zero_then_flush();
      t_idle_flush();
      t_abort_single();
      t_overflow();
      t_dual_order();
      t_dual_flush();
      t_dual_abort();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule